// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block sits beside a byte-wide RAM on a synchronous bus and watches the accesses that the host makes. Commands are hidden in the order of read addresses, so the RAM keeps the pin set of a plain SRAM. Five fixed reads followed by a sixth read at one of two final addresses ask for one of two actions. One final address asks to copy the working RAM into backup storage (save). The other asks to reload the working RAM from backup (restore). The detector only tracks progress. It raises a one-cycle pulse on `save_pulse` or `restore_pulse`, and other logic carries out the copy.

Every access is sampled once, in the cycle where `acc_vld` is high. Cycles without a strobe leave progress unchanged. A write anywhere in the sequence cancels it. A read that does not match the expected step also cancels it, unless that read is itself at the first address, in which case it starts a new attempt. While `busy` is high, the block is held idle and disregards the bus.

Top module: `rdseq_cmd_detect`

## Requirements
- R1: After reset, both pulse outputs are low and no progress is held, so the final read alone issues nothing.
- R2: Reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F raise `save_pulse` for exactly one cycle, in the cycle after the strobe of the sixth read.
- R3: The same five reads followed by a read at 0x0F0E raise `restore_pulse` for exactly one cycle, in the cycle after the strobe of the sixth read.
- R4: A write strobe (`acc_rd` = 0) at any point cancels the sequence, and no pulse follows until a full new sequence is read.
- R5: A read at an address other than the expected next one cancels the sequence, including a sixth read at any address except 0x0F0F or 0x0F0E.
- R6: A cancelling read at 0x0000 counts as the first step of a new sequence.
- R7: Cycles with `acc_vld` low, in any number, between the accesses of a sequence do not change its progress.
- R8: While `busy` is high, strobes are disregarded, progress returns to idle and no pulse is issued.
- R9: `save_pulse` and `restore_pulse` are never high together, and each is high only in the cycle that follows a qualifying read strobe.
- R10: After a command is issued, the detector is idle, and a lone repeated final read issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | High while a save or restore is running; the detector is held idle |
| acc_vld | input | 1 | One access is present on the bus in this cycle |
| acc_rd | input | 1 | 1 = read, 0 = write; meaningful when `acc_vld` is high |
| acc_addr | input | ADDR_W (13) | Byte address of the access |
| save_pulse | output | 1 | One-cycle request to save the RAM into backup |
| restore_pulse | output | 1 | One-cycle request to reload the RAM from backup |

## Verification
Both complete sequences are run back to back, and again with idle gaps of varying length. A correct result here shows that the final address alone chooses between the two pulses, and that unstrobed cycles are not counted. Cancellation is tried three ways: a write in mid-sequence, a wrong read in mid-sequence, and a wrong sixth address. Each is followed by the rest of the sequence, so a block that skips the stray access would fire where it must not. A stray read of 0x0000 in mid-sequence, followed by the remaining five addresses, separates a detector that restarts at step one from one that falls back to idle. The busy cases and a lone final read after a command show that no stale progress remains.

// File: rtl/rdseq_cmd_detect.sv
module rdseq_cmd_detect #(
  parameter int unsigned ADDR_W   = 13,
  parameter logic [ADDR_W-1:0] SEQ_A0 = 13'h0000,
  parameter logic [ADDR_W-1:0] SEQ_A1 = 13'h1555,
  parameter logic [ADDR_W-1:0] SEQ_A2 = 13'h0AAA,
  parameter logic [ADDR_W-1:0] SEQ_A3 = 13'h1FFF,
  parameter logic [ADDR_W-1:0] SEQ_A4 = 13'h10F0,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RESTORE_ADDR = 13'h0F0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              acc_vld,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              save_pulse,
  output logic              restore_pulse
);
  localparam int unsigned PREFIX = 5;
  localparam int unsigned STEP_W = $clog2(PREFIX + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX);

  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] want;

  always_comb begin
    unique case (step_q)
      STEP_W'(0): want = SEQ_A0;
      STEP_W'(1): want = SEQ_A1;
      STEP_W'(2): want = SEQ_A2;
      STEP_W'(3): want = SEQ_A3;
      default:    want = SEQ_A4;
    endcase
  end

  wire take    = acc_vld & ~busy;
  wire rd_take = take & acc_rd;
  wire at_last = (step_q == LAST);
  wire is_save = rd_take & at_last & (acc_addr == SAVE_ADDR);
  wire is_rest = rd_take & at_last & (acc_addr == RESTORE_ADDR);
  wire advance = rd_take & ~at_last & (acc_addr == want);
  wire restart = rd_take & (acc_addr == SEQ_A0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q        <= '0;
      save_pulse    <= 1'b0;
      restore_pulse <= 1'b0;
    end else begin
      save_pulse    <= is_save;
      restore_pulse <= is_rest;
      if (busy)
        step_q <= '0;
      else if (take) begin
        if (is_save || is_rest) step_q <= '0;
        else if (advance)       step_q <= step_q + STEP_W'(1);
        else if (restart)       step_q <= STEP_W'(1);
        else                    step_q <= '0;
      end
    end
  end
endmodule

module rdseq_cmd_detect_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RESTORE_ADDR = 13'h0F0E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              acc_vld,
  input logic              acc_rd,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              save_pulse,
  input logic              restore_pulse
);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(save_pulse && restore_pulse));
  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !save_pulse && !restore_pulse);
  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_rd) |=> !save_pulse && !restore_pulse);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> !save_pulse && !restore_pulse);
  p_save_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_rd && !busy && acc_addr != SAVE_ADDR) |=> !save_pulse);
  p_rest_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_rd && !busy && acc_addr != RESTORE_ADDR) |=> !restore_pulse);
  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (save_pulse || restore_pulse) |=> !save_pulse && !restore_pulse);
endmodule

bind rdseq_cmd_detect rdseq_cmd_detect_chk #(
  .ADDR_W(ADDR_W), .SAVE_ADDR(SAVE_ADDR), .RESTORE_ADDR(RESTORE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .acc_vld(acc_vld), .acc_rd(acc_rd),
  .acc_addr(acc_addr), .save_pulse(save_pulse), .restore_pulse(restore_pulse)
);

// File: tb/tb_rdseq_cmd_detect.sv
`timescale 1ns/1ps
module tb_rdseq_cmd_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0;
  logic acc_vld = 1'b0;
  logic acc_rd = 1'b1;
  logic [12:0] acc_addr = '0;
  logic save_pulse, restore_pulse;
  int checks = 0;
  int errors = 0;
  logic got_s, got_r;

  always #5 clk = ~clk;

  rdseq_cmd_detect dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .acc_vld(acc_vld), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .save_pulse(save_pulse), .restore_pulse(restore_pulse)
  );

  task automatic check(input string req, input logic s, input logic r,
                       input logic es, input logic er);
    checks++;
    if (s !== es || r !== er) begin
      errors++;
      $display("FAIL %s: save/restore = %b/%b, expected %b/%b", req, s, r, es, er);
    end
  endtask

  task automatic access(input logic rd, input logic [12:0] a, input int gap);
    for (int i = 0; i < gap; i++) @(negedge clk);
    @(negedge clk);
    acc_vld = 1'b1; acc_rd = rd; acc_addr = a;
    @(posedge clk); #1;
    got_s = save_pulse; got_r = restore_pulse;
    @(negedge clk);
    acc_vld = 1'b0; acc_rd = 1'b1; acc_addr = 13'h1ABC;
  endtask

  task automatic prefix(input int gap);
    access(1, 13'h0000, gap); access(1, 13'h1555, gap); access(1, 13'h0AAA, gap);
    access(1, 13'h1FFF, gap); access(1, 13'h10F0, gap);
  endtask

  task automatic check_prefix_quiet(input string req);
    access(1, 13'h0000, 0); check(req, got_s, got_r, 0, 0);
    access(1, 13'h1555, 0); check(req, got_s, got_r, 0, 0);
    access(1, 13'h0AAA, 0); check(req, got_s, got_r, 0, 0);
    access(1, 13'h1FFF, 0); check(req, got_s, got_r, 0, 0);
    access(1, 13'h10F0, 0); check(req, got_s, got_r, 0, 0);
  endtask

  task automatic t_reset();
    check("R1 reset outputs", save_pulse, restore_pulse, 0, 0);
    access(1, 13'h0F0F, 0);
    check("R1 final read from idle", got_s, got_r, 0, 0);
  endtask

  task automatic t_save();
    check_prefix_quiet("R2 prefix quiet");
    access(1, 13'h0F0F, 0);
    check("R2 save pulse", got_s, got_r, 1, 0);
    @(posedge clk); #1;
    check("R2 save pulse one cycle", save_pulse, restore_pulse, 0, 0);
  endtask

  task automatic t_restore();
    prefix(0);
    access(1, 13'h0F0E, 0);
    check("R3 restore pulse", got_s, got_r, 0, 1);
    @(posedge clk); #1;
    check("R3 restore pulse one cycle", save_pulse, restore_pulse, 0, 0);
  endtask

  task automatic t_write_abort();
    access(1, 13'h0000, 0); access(1, 13'h1555, 0); access(1, 13'h0AAA, 0);
    access(0, 13'h1FFF, 0);
    check("R4 write strobe quiet", got_s, got_r, 0, 0);
    access(1, 13'h1FFF, 0); access(1, 13'h10F0, 0); access(1, 13'h0F0F, 0);
    check("R4 write cancels", got_s, got_r, 0, 0);
    prefix(0); access(0, 13'h0F0F, 0);
    check("R4 write as sixth access", got_s, got_r, 0, 0);
    access(1, 13'h0F0F, 0);
    check("R4 read after sixth write", got_s, got_r, 0, 0);
  endtask

  task automatic t_wrong_read();
    access(1, 13'h0000, 0); access(1, 13'h1555, 0); access(1, 13'h0AAA, 0);
    access(1, 13'h1234, 0);
    access(1, 13'h1FFF, 0); access(1, 13'h10F0, 0); access(1, 13'h0F0E, 0);
    check("R5 wrong read cancels", got_s, got_r, 0, 0);
    prefix(0); access(1, 13'h0F0D, 0);
    check("R5 wrong sixth address", got_s, got_r, 0, 0);
    access(1, 13'h0F0F, 0);
    check("R5 no retry of sixth", got_s, got_r, 0, 0);
  endtask

  task automatic t_restart();
    access(1, 13'h0000, 0); access(1, 13'h1555, 0); access(1, 13'h0AAA, 0);
    access(1, 13'h0000, 0);
    access(1, 13'h1555, 0); access(1, 13'h0AAA, 0); access(1, 13'h1FFF, 0);
    access(1, 13'h10F0, 0); access(1, 13'h0F0F, 0);
    check("R6 stray 0x0000 restarts", got_s, got_r, 1, 0);
    access(1, 13'h0000, 0); access(1, 13'h0000, 0); access(1, 13'h1555, 0);
    access(1, 13'h0AAA, 0); access(1, 13'h1FFF, 0); access(1, 13'h10F0, 0);
    access(1, 13'h0F0E, 0);
    check("R6 repeated first address", got_s, got_r, 0, 1);
  endtask

  task automatic t_gaps();
    access(1, 13'h0000, 3); access(1, 13'h1555, 0); access(1, 13'h0AAA, 7);
    access(1, 13'h1FFF, 1); access(1, 13'h10F0, 12); access(1, 13'h0F0F, 5);
    check("R7 idle gaps save", got_s, got_r, 1, 0);
    prefix(2); access(1, 13'h0F0E, 9);
    check("R7 idle gaps restore", got_s, got_r, 0, 1);
  endtask

  task automatic t_busy();
    access(1, 13'h0000, 0); access(1, 13'h1555, 0); access(1, 13'h0AAA, 0);
    @(negedge clk); busy = 1'b1;
    @(negedge clk); busy = 1'b0;
    access(1, 13'h1FFF, 0); access(1, 13'h10F0, 0); access(1, 13'h0F0F, 0);
    check("R8 busy clears progress", got_s, got_r, 0, 0);
    prefix(0);
    @(negedge clk); busy = 1'b1;
    access(1, 13'h0F0F, 0);
    check("R8 read during busy", got_s, got_r, 0, 0);
    @(negedge clk); busy = 1'b0;
    access(1, 13'h0F0F, 0);
    check("R8 no progress after busy", got_s, got_r, 0, 0);
  endtask

  task automatic t_after_cmd();
    prefix(0); access(1, 13'h0F0F, 0);
    check("R10 save issued", got_s, got_r, 1, 0);
    access(1, 13'h0F0F, 0);
    check("R10 lone repeat quiet", got_s, got_r, 0, 0);
    access(1, 13'h0F0E, 0);
    check("R10 lone restore quiet", got_s, got_r, 0, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_save();
    t_restore();
    t_write_abort();
    t_wrong_read();
    t_restart();
    t_gaps();
    t_busy();
    t_after_cmd();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule